// File: doc/BRIEF.md
# Memory-Mapped Pad Function and GPIO Controller

This block owns a bank of pads and lets software configure each one through a 32-bit register port. Every pad has its own register window. The window holds a configuration word and a value word. The configuration word sets four things:

- the weak bias;
- a drive-strength code;
- a GPIO output enable;
- a function selector that picks what is steered onto the pad. The choices are the software GPIO level or one of several alternate peripheral sources.

The value word carries the software output level and a synchronized copy of the pad input.

A single shared slew word lives in a second address region. It packs 2-bit slew codes for the pads that support slew control. The bit positions of these codes are irregular, and several pads have no slew code at all. The block sits between a register bus and the pad ring. It presents per-pad out, enable, bias, drive and slew codes to the analog pad cells. It also takes the peripheral out and enable signals from the audio and serial peripherals.

Top module: `gpio_pad_bank`

## Requirements
- R1: With `bus_region` = 0, pad n's window starts at byte address n × 0x1000. The configuration word is at window offset 0x0 and the value word is at window offset 0x4. With `bus_region` = 1, the slew word is at address 0xA000.
- R2: The configuration word fields are pull at bits [1:0], function select at bits [5:2], drive code at bits [8:6] and GPIO output enable at bit 9. These ten bits read back as written and all higher bits read as zero. The pull code appears on `pad_pull` and the drive code on `pad_drive` from the cycle after the write.
- R3: Value word bit 1 holds the software output level and reads back. Value word bit 0 is read-only, so writes to it have no effect. All other value word bits read as zero.
- R4: With function select 0, `pad_out` follows value bit 1 and `pad_oe` follows configuration bit 9.
- R5: With function select k in 1..4, `pad_out` and `pad_oe` follow `alt_out` and `alt_oe` bit n×4 + (k−1), combinationally.
- R6: With function select 5..15 (reserved), `pad_out` and `pad_oe` are both 0, whatever the configuration and value words hold.
- R7: The slew word gives 2-bit codes to pads 0,1,2,3,4,5,10,11 at bit offsets 0,2,4,8,10,12,16,18. Each of these codes drives that pad's `pad_slew` field. Pads without a code output slew 0.
- R8: Writes to any unmapped address are ignored, and such addresses read as zero. This covers pad windows 14 and 15, window offsets other than 0x0 and 0x4, and slew-region addresses other than 0xA000. Slew word bits that no pad owns also read as zero and ignore writes.
- R9: After reset, all configuration words, value output bits, slew codes and synchronizer stages are zero. The pads then show GPIO mode, no bias, drive code 0 (2 mA) and output disabled.
- R10: Value bit 0 returns `pad_in` through a two-flop synchronizer. It shows the level sampled two rising clock edges earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_region | input | 1 | 0 = pad windows, 1 = slew region |
| bus_addr | input | 16 | Byte address within the region |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for the current address |
| pad_in | input | 14 | Raw pad input levels |
| alt_out | input | 56 | Alternate source levels, 4 per pad |
| alt_oe | input | 56 | Alternate source enables, 4 per pad |
| pad_out | output | 14 | Level driven to each pad |
| pad_oe | output | 14 | Output enable to each pad |
| pad_pull | output | 28 | 2-bit bias code per pad: 0 none, 1 down, 2 keeper, 3 up |
| pad_drive | output | 42 | 3-bit drive code per pad, (code+1)×2 mA |
| pad_slew | output | 28 | 2-bit slew code per pad |

## Verification
The bench builds the block with its default parameters: 14 pads, four alternate sources per pad and a 16-bit address. With these values the 4-bit window index also reaches windows 14 and 15, so the unmapped upper windows can be exercised alongside the last real pad. The 4-bit function field reaches all eleven reserved selector values. A behavioural model runs beside the block and is compared on every cycle. It checks all pad outputs and the read data for whatever address is presented, while random writes, pad inputs and peripheral sources change.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int BUS_W     = 32;
  localparam int WIN_BITS  = 12;
  localparam int CFG_W     = 10;
  localparam int FUNC_W    = 4;
  localparam int SLEW_W    = 2;
  localparam int CFG_OFS   = 'h000;
  localparam int VAL_OFS   = 'h004;
  localparam int SLEW_ADDR = 'hA000;

  // bit 9 oe, [8:6] drive, [5:2] func, [1:0] pull
  typedef struct packed {
    logic              oe;
    logic [2:0]        drive;
    logic [FUNC_W-1:0] func;
    logic [1:0]        pull;
  } pad_cfg_t;

  // bit position of a pad's code inside the shared slew word, -1 = none
  function automatic int slew_bit_pos(int pad);
    case (pad)
      0:       return 0;
      1:       return 2;
      2:       return 4;
      3:       return 8;
      4:       return 10;
      5:       return 12;
      10:      return 16;
      11:      return 18;
      default: return -1;
    endcase
  endfunction

  function automatic logic [BUS_W-1:0] slew_own_mask(int npads);
    logic [BUS_W-1:0] m;
    m = '0;
    for (int p = 0; p < npads; p++)
      if (slew_bit_pos(p) >= 0) m[slew_bit_pos(p) +: SLEW_W] = '1;
    return m;
  endfunction

  function automatic logic sel_reserved(logic [FUNC_W-1:0] f, int nalt);
    return int'(f) > nalt;
  endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      q      <= 1'b0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_pad_slot.sv
module gpio_pad_slot
  import gpio_bank_pkg::*;
#(
  parameter int ALT_N = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              val_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              out_wdata,
  input  logic              pad_in,
  input  logic [ALT_N-1:0]  alt_out,
  input  logic [ALT_N-1:0]  alt_oe,
  output logic [CFG_W-1:0]  cfg_q_o,
  output logic              out_q_o,
  output logic              in_sync_o,
  output logic              pad_out,
  output logic              pad_oe,
  output logic [1:0]        pull,
  output logic [2:0]        drive
);
  pad_cfg_t cfg_q;
  logic     out_q;
  logic     in_sync;
  logic     sel_gpio;
  logic     sel_rsvd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      out_q <= 1'b0;
    end else begin
      if (cfg_we) cfg_q <= pad_cfg_t'(cfg_wdata);
      if (val_we) out_q <= out_wdata;
    end
  end

  gpio_sync2 u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (in_sync)
  );

  assign sel_gpio = (cfg_q.func == '0);
  assign sel_rsvd = sel_reserved(cfg_q.func, ALT_N);

  always_comb begin
    pad_out = 1'b0;
    pad_oe  = 1'b0;
    if (sel_gpio) begin
      pad_out = out_q;
      pad_oe  = cfg_q.oe;
    end else begin
      for (int k = 0; k < ALT_N; k++) begin
        if (cfg_q.func == FUNC_W'(k + 1)) begin
          pad_out = alt_out[k];
          pad_oe  = alt_oe[k];
        end
      end
    end
  end

  assign pull      = cfg_q.pull;
  assign drive     = cfg_q.drive;
  assign cfg_q_o   = cfg_q;
  assign out_q_o   = out_q;
  assign in_sync_o = in_sync;

  // cycles since reset, used to arm the synchronizer latency check
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             warm_q <= '0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  a_r2_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_q));

  a_r3_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !val_we |=> $stable(out_q));

  a_r6_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    sel_rsvd |-> (!pad_out && !pad_oe));

  a_r10_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd2) |-> (in_sync == $past(pad_in, 2)));

endmodule

// File: rtl/gpio_slew_reg.sv
module gpio_slew_reg
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PADS = 14
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [BUS_W-1:0]           wdata,
  output logic [BUS_W-1:0]           rd_data,
  output logic [NUM_PADS*SLEW_W-1:0] pad_slew
);
  localparam logic [BUS_W-1:0] OWN_MASK = slew_own_mask(NUM_PADS);

  for (genvar g = 0; g < NUM_PADS; g++) begin : g_pad
    localparam int POS = slew_bit_pos(g);
    if (POS >= 0) begin : g_own
      logic [SLEW_W-1:0] code_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  code_q <= '0;
        else if (we) code_q <= wdata[POS +: SLEW_W];
      end
      assign pad_slew[g*SLEW_W +: SLEW_W] = code_q;
    end else begin : g_none
      assign pad_slew[g*SLEW_W +: SLEW_W] = '0;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int g = 0; g < NUM_PADS; g++)
      if (slew_bit_pos(g) >= 0)
        rd_data[slew_bit_pos(g) +: SLEW_W] = pad_slew[g*SLEW_W +: SLEW_W];
  end

  a_r7_slew_load: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (rd_data == ($past(wdata) & OWN_MASK)));

  a_r8_slew_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(rd_data));

endmodule

// File: rtl/gpio_pad_bank.sv
module gpio_pad_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PADS = 14,
  parameter int ALT_N    = 4,
  parameter int ADDR_W   = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_region,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic                       bus_wr,
  input  logic [BUS_W-1:0]           bus_wdata,
  output logic [BUS_W-1:0]           bus_rdata,
  input  logic [NUM_PADS-1:0]        pad_in,
  input  logic [NUM_PADS*ALT_N-1:0]  alt_out,
  input  logic [NUM_PADS*ALT_N-1:0]  alt_oe,
  output logic [NUM_PADS-1:0]        pad_out,
  output logic [NUM_PADS-1:0]        pad_oe,
  output logic [NUM_PADS*2-1:0]      pad_pull,
  output logic [NUM_PADS*3-1:0]      pad_drive,
  output logic [NUM_PADS*SLEW_W-1:0] pad_slew
);
  localparam int IDX_W = ADDR_W - WIN_BITS;

  logic [IDX_W-1:0]    win_idx;
  logic [WIN_BITS-1:0] win_ofs;
  logic                win_hit, hit_cfg, hit_val, hit_slew;
  logic [NUM_PADS-1:0] cfg_we, val_we;
  logic                slew_we;
  logic [BUS_W-1:0]    slew_rd;

  logic [CFG_W-1:0]    cfg_q  [NUM_PADS];
  logic [NUM_PADS-1:0] out_q;
  logic [NUM_PADS-1:0] in_sync;

  assign win_idx  = bus_addr[ADDR_W-1:WIN_BITS];
  assign win_ofs  = bus_addr[WIN_BITS-1:0];
  assign win_hit  = !bus_region && (int'(win_idx) < NUM_PADS);
  assign hit_cfg  = win_hit && (win_ofs == WIN_BITS'(CFG_OFS));
  assign hit_val  = win_hit && (win_ofs == WIN_BITS'(VAL_OFS));
  assign hit_slew = bus_region && (bus_addr == ADDR_W'(SLEW_ADDR));
  assign slew_we  = bus_wr && hit_slew;

  for (genvar g = 0; g < NUM_PADS; g++) begin : g_slot
    assign cfg_we[g] = bus_wr && hit_cfg && (win_idx == IDX_W'(g));
    assign val_we[g] = bus_wr && hit_val && (win_idx == IDX_W'(g));

    gpio_pad_slot #(.ALT_N(ALT_N)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we[g]),
      .val_we    (val_we[g]),
      .cfg_wdata (bus_wdata[CFG_W-1:0]),
      .out_wdata (bus_wdata[1]),
      .pad_in    (pad_in[g]),
      .alt_out   (alt_out[g*ALT_N +: ALT_N]),
      .alt_oe    (alt_oe[g*ALT_N +: ALT_N]),
      .cfg_q_o   (cfg_q[g]),
      .out_q_o   (out_q[g]),
      .in_sync_o (in_sync[g]),
      .pad_out   (pad_out[g]),
      .pad_oe    (pad_oe[g]),
      .pull      (pad_pull[g*2 +: 2]),
      .drive     (pad_drive[g*3 +: 3])
    );
  end

  gpio_slew_reg #(.NUM_PADS(NUM_PADS)) u_slew (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (slew_we),
    .wdata    (bus_wdata),
    .rd_data  (slew_rd),
    .pad_slew (pad_slew)
  );

  always_comb begin
    bus_rdata = '0;
    if (hit_slew) begin
      bus_rdata = slew_rd;
    end else begin
      for (int g = 0; g < NUM_PADS; g++) begin
        if (win_idx == IDX_W'(g)) begin
          if (hit_cfg) bus_rdata = {{(BUS_W-CFG_W){1'b0}}, cfg_q[g]};
          if (hit_val) bus_rdata = {{(BUS_W-2){1'b0}}, out_q[g], in_sync[g]};
        end
      end
    end
  end

  a_r1_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cfg_we, val_we, slew_we}));

  a_r8_upper_window_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_region && (int'(win_idx) >= NUM_PADS)) |-> (bus_rdata == '0));

  a_r8_unmapped_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !hit_cfg && !hit_val && !hit_slew) |-> (cfg_we == '0 && val_we == '0));

endmodule

// File: tb/gpio_pad_bank_test.sv
module gpio_pad_bank_test;
  localparam int NP = 14;
  localparam int NA = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_region = 1'b0;
  logic [15:0]   bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP*NA-1:0] alt_out = '0;
  logic [NP*NA-1:0] alt_oe = '0;
  logic [NP-1:0] pad_out, pad_oe;
  logic [NP*2-1:0] pad_pull;
  logic [NP*3-1:0] pad_drive;
  logic [NP*2-1:0] pad_slew;

  always #5 clk = ~clk;

  gpio_pad_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_region(bus_region), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .alt_out(alt_out), .alt_oe(alt_oe),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull(pad_pull),
    .pad_drive(pad_drive), .pad_slew(pad_slew)
  );

  // reference model state
  int m_cfg [NP];
  int m_out [NP];
  int m_slw [NP];
  int s1 [NP];
  int s2 [NP];
  int slew_pos [NP] = '{0, 2, 4, 8, 10, 12, -1, -1, -1, -1, 16, 18, -1, -1};

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;
  int cyc = 0;

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) begin
        m_cfg[p] = 0; m_out[p] = 0; m_slw[p] = 0; s1[p] = 0; s2[p] = 0;
      end
    end else begin
      for (int p = 0; p < NP; p++) begin
        s2[p] = s1[p];
        s1[p] = int'(pad_in[p]);
      end
      if (bus_wr) begin
        if (!bus_region) begin
          int idx, off;
          idx = int'(bus_addr) / 4096;
          off = int'(bus_addr) % 4096;
          if (idx < NP && off == 0) m_cfg[idx] = int'(bus_wdata) & 'h3FF;
          if (idx < NP && off == 4) m_out[idx] = (int'(bus_wdata) >> 1) & 1;
        end else if (bus_addr == 16'hA000) begin
          for (int p = 0; p < NP; p++)
            if (slew_pos[p] >= 0) m_slw[p] = (int'(bus_wdata) >> slew_pos[p]) & 3;
        end
      end
    end
  end

  // compare every cycle, 2 ns after the rising edge
  always @(posedge clk) begin
    #2;
    if (!done) begin
      for (int p = 0; p < NP; p++) begin
        int sel, eo, eoe;
        string tg;
        sel = (m_cfg[p] >> 2) & 15;
        if (sel == 0) begin
          eo = m_out[p]; eoe = (m_cfg[p] >> 9) & 1; tg = "R4 gpio route";
        end else if (sel <= NA) begin
          eo = int'(alt_out[p*NA + sel - 1]); eoe = int'(alt_oe[p*NA + sel - 1]);
          tg = "R5 alternate route";
        end else begin
          eo = 0; eoe = 0; tg = "R6 reserved select";
        end
        if (!rst_n) tg = "R9 reset state";
        check(tg, int'(pad_out[p]), eo);
        check(tg, int'(pad_oe[p]), eoe);
        check(rst_n ? "R2 pull code" : "R9 reset pull", int'(pad_pull[p*2 +: 2]), m_cfg[p] & 3);
        check(rst_n ? "R2 drive code" : "R9 reset drive", int'(pad_drive[p*3 +: 3]), (m_cfg[p] >> 6) & 7);
        check(rst_n ? "R7 slew code" : "R9 reset slew", int'(pad_slew[p*2 +: 2]), m_slw[p]);
      end
      begin
        int exp_rd, idx, off;
        string tg;
        exp_rd = 0;
        idx = int'(bus_addr) / 4096;
        off = int'(bus_addr) % 4096;
        tg = "R8 unmapped read";
        if (bus_region) begin
          if (bus_addr == 16'hA000) begin
            tg = "R7 slew word";
            for (int p = 0; p < NP; p++)
              if (slew_pos[p] >= 0) exp_rd |= m_slw[p] << slew_pos[p];
          end
        end else if (idx < NP && off == 0) begin
          tg = "R1 R2 config word"; exp_rd = m_cfg[idx];
        end else if (idx < NP && off == 4) begin
          tg = "R1 R3 R10 value word"; exp_rd = (m_out[idx] << 1) | s2[idx];
        end
        check(tg, int'(bus_rdata), exp_rd);
      end
    end
  end

  task automatic bus_write(bit region, int addr, int data);
    @(negedge clk);
    bus_region = region; bus_addr = 16'(addr); bus_wdata = 32'(data); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_look(bit region, int addr);
    @(negedge clk);
    bus_region = region; bus_addr = 16'(addr); bus_wr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);   // R9: reset state checked each cycle
    rst_n = 1'b1;
    bus_look(0, 'h3000);
    // R6: reserved select 9 with oe and level set
    bus_write(0, 'h3000, (1 << 9) | (7 << 6) | (9 << 2) | 3);
    bus_write(0, 'h3004, 'hFFFF_FFFF);   // R3: bit 0 write ignored
    bus_look(0, 'h3004);
    // R4: GPIO mode with output enable
    bus_write(0, 'h0000, 'h200);
    bus_write(0, 'h0004, 2);
    // R5: alternate sources on pads 5 and 13
    alt_out = '1; alt_oe = '1;
    bus_write(0, 'h5000, (2 << 2) | (2 << 6) | 1);
    bus_write(0, 'hD000, (4 << 2) | 2);
    bus_look(0, 'hD000);
    // R7: all slew bits set, only owned bits stick
    bus_write(1, 'hA000, 'hFFFF_FFFF);
    bus_look(1, 'hA000);
    // R8: unmapped window, offset and slew-region addresses
    bus_write(0, 'hE000, 'h3FF);
    bus_write(0, 'hF004, 'h3FF);
    bus_write(0, 'h2008, 'h3FF);
    bus_write(1, 'hA004, 'hFFFF_FFFF);
    bus_write(1, 'h2000, 'h0);
    bus_look(0, 'hE000);
    bus_look(0, 'h2000);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      int idx, sel;
      @(negedge clk);
      pad_in  = NP'($urandom);
      alt_out = {$urandom, $urandom};
      alt_oe  = {$urandom, $urandom};
      bus_region = ($urandom_range(0, 7) == 0);
      if (bus_region) begin
        sel = $urandom_range(0, 3);
        bus_addr = (sel == 2) ? 16'hA004 : (sel == 3) ? 16'h2000 : 16'hA000;
      end else begin
        idx = $urandom_range(0, 15);
        sel = $urandom_range(0, 4);
        bus_addr = 16'(idx * 4096 + ((sel == 0) ? 0 : (sel == 1) ? 4 : (sel == 2) ? 8 :
                                     (sel == 3) ? 'h800 : 4));
      end
      bus_wdata = $urandom;
      bus_wr = ($urandom_range(0, 1) == 1);
    end
    @(negedge clk);
    bus_wr = 1'b0;
    // R9: reset again mid-run
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule